// File: doc/BRIEF.md
# I2C EEPROM write engine

This block is an I2C target that models the write side of a serial EEPROM with 16-bit byte addressing. It watches already-synchronised SCL and SDA lines and finds START and STOP conditions. It accepts a device select byte that carries three chip-enable bits, then takes two address bytes and then one or more data bytes. It answers each accepted byte by pulling SDA low through an open-drain enable.

Data bytes collect in a page buffer. The buffer is written into a small on-chip byte array during a timed internal write cycle. That cycle starts only on a STOP that arrives right after an acknowledge. While the cycle runs the block ignores the bus entirely. The write-control input blocks a transaction if it is seen high at any time from the START to the end of the second address byte.

The block keeps an internal address counter up to date for a read path to use later. The array itself has a combinational read port.

Top module: `i2c_ee_write`

## Requirements
- R1: A select byte is acknowledged only if it equals {4'b1010, ce_i[2:0], 1'b0}, sent MSB first. The lowest bit, 0, marks a write. Any other byte is left unacknowledged, whether the upper nibble differs, the chip-enable bits differ or the lowest bit is 1, and the block then ignores the bus until the next START.
- R2: Two address bytes follow a matching select byte, the high byte first, and both are acknowledged. Of the resulting 16-bit address, only the low MEM_AW bits select a location in the array.
- R3: Each data byte is acknowledged and buffered at the next page offset. The offset is formed by the low PAGE_AW address bits and wraps within the page. When more bytes arrive than fit in a page, later bytes replace earlier ones at the same offset.
- R4: If wc_i is high at any sampled cycle from the START through the end of the second address byte, every data byte goes unacknowledged and the array is not modified. A high level on wc_i only during the data phase has no effect.
- R5: A write cycle starts only on a STOP that follows an acknowledged data byte with exactly one SCL rise after that byte's ACK clock. A STOP anywhere else, a STOP with no data byte, or a repeated START discards the buffered bytes and leaves the array unchanged.
- R6: busy_o goes high one clock after a qualifying STOP and stays high for TW_CYCLES clocks, or for 2**PAGE_AW+1 clocks if that is larger. While it is high, nothing on the bus is acknowledged.
- R7: The address counter addr_cnt_o resets to 0. It changes only when a write cycle completes, and it then takes the 16-bit value of the last modified address plus one.
- R8: sda_oe_o is high only during the ACK clock of an accepted byte. It changes only while SCL is low.
- R9: The array resets to all zeros and is read combinationally through mem_raddr_i/mem_rdata_o. Its contents change only during a write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| wc_i | input | 1 | Write control, high blocks writes |
| ce_i | input | 3 | Chip-enable pins compared with the select byte |
| sda_oe_o | output | 1 | High pulls SDA low |
| busy_o | output | 1 | Internal write cycle in progress |
| addr_cnt_o | output | 16 | Internal address counter |
| mem_raddr_i | input | MEM_AW | Array read address |
| mem_rdata_o | output | 8 | Array read data, combinational |

## Verification
The ACK enable is registered on the clock that first sees SCL low after the eighth bit, and it is released the same way after the ACK clock. The bench therefore samples the acknowledge in the middle of the SCL high phase, two clocks after the rising edge. busy_o rises one clock after the STOP and falls TW_CYCLES clocks later, with addr_cnt_o updated on that same clock. The bench checks busy_o four clocks after the STOP, and it checks busy_o, the counter and the whole array ten clocks after the cycle is due to end. The read port has no latency, so the array is compared one nanosecond after each read address is applied.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADRH, ST_ADRL, ST_DATA, ST_SKIP, ST_BUSY
  } ee_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam logic [3:0] BIT_ACK  = 4'd8;
  localparam logic [3:0] BIT_REL  = 4'd9;
endpackage

// File: rtl/i2c_ee_bus_mon.sv
module i2c_ee_bus_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_ee_page_store.sv
module i2c_ee_page_store #(
  parameter int MEM_AW  = 8,
  parameter int PAGE_AW = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      wr_en_i,
  input  logic [PAGE_AW-1:0]        wr_off_i,
  input  logic [7:0]                wr_data_i,
  input  logic                      commit_i,
  input  logic [MEM_AW-PAGE_AW-1:0] page_i,
  input  logic [MEM_AW-1:0]         raddr_i,
  output logic [7:0]                rdata_o
);
  localparam int PAGE = 1 << PAGE_AW;
  localparam int MEM  = 1 << MEM_AW;
  localparam logic [PAGE_AW-1:0] IDX_ONE = 1;

  logic [7:0]                pbuf [PAGE];
  logic [7:0]                mem  [MEM];
  logic [PAGE-1:0]           vld_q;
  logic                      active_q;
  logic [PAGE_AW-1:0]        idx_q;
  logic [MEM_AW-PAGE_AW-1:0] base_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) pbuf[wr_off_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= '0;
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else if (commit_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      base_q   <= page_i;
    end else if (active_q) begin
      idx_q <= idx_q + IDX_ONE;
      if (&idx_q) begin
        active_q <= 1'b0;
        vld_q    <= '0;
      end
    end else if (clr_i) begin
      vld_q <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_off_i] <= 1'b1;
    end
  end

  // array sweeps the page one offset per clock during the write cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM; i++) mem[i] <= '0;
    end else if (active_q && vld_q[idx_q]) begin
      mem[{base_q, idx_q}] <= pbuf[idx_q];
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
  import i2c_ee_pkg::*;
#(
  parameter int MEM_AW    = 8,
  parameter int PAGE_AW   = 6,
  parameter int TW_CYCLES = 300
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      scl_rise_i,
  input  logic                      scl_fall_i,
  input  logic                      start_i,
  input  logic                      stop_i,
  input  logic                      sda_i,
  input  logic                      wc_i,
  input  logic [2:0]                ce_i,
  output logic                      sda_oe_o,
  output logic                      busy_o,
  output logic [15:0]               addr_cnt_o,
  output logic                      wr_en_o,
  output logic [PAGE_AW-1:0]        wr_off_o,
  output logic [7:0]                wr_data_o,
  output logic                      clr_o,
  output logic                      commit_o,
  output logic [MEM_AW-PAGE_AW-1:0] page_o
);
  localparam int PAGE   = 1 << PAGE_AW;
  localparam int TW_EFF = (TW_CYCLES > PAGE) ? TW_CYCLES : PAGE + 1;
  localparam int TW_W   = $clog2(TW_EFF + 1);
  localparam logic [PAGE_AW-1:0] OFF_ONE = 1;
  localparam logic [TW_W-1:0]    TW_ONE  = 1;

  ee_state_e            state_q;
  logic [3:0]           cnt_q;
  logic [7:0]           sh_q;
  logic [7:0]           adr_msb_q;
  logic [15-PAGE_AW:0]  page_q;
  logic [PAGE_AW-1:0]   off_q;
  logic [15:0]          last_q;
  logic                 wc_seen_q;
  logic                 have_data_q;
  logic [TW_W-1:0]      tw_q;
  logic                 sel_ok;

  assign sel_ok = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:1] == ce_i) && !sh_q[0];
  assign busy_o = (state_q == ST_BUSY);
  assign page_o = page_q[MEM_AW-PAGE_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      adr_msb_q   <= '0;
      page_q      <= '0;
      off_q       <= '0;
      last_q      <= '0;
      wc_seen_q   <= 1'b0;
      have_data_q <= 1'b0;
      tw_q        <= '0;
      sda_oe_o    <= 1'b0;
      addr_cnt_o  <= '0;
      wr_en_o     <= 1'b0;
      wr_off_o    <= '0;
      wr_data_o   <= '0;
      clr_o       <= 1'b0;
      commit_o    <= 1'b0;
    end else begin
      wr_en_o  <= 1'b0;
      clr_o    <= 1'b0;
      commit_o <= 1'b0;
      if (state_q == ST_BUSY) begin
        if (tw_q == TW_ONE) begin
          state_q    <= ST_IDLE;
          addr_cnt_o <= last_q + 16'd1;
        end else begin
          tw_q <= tw_q - TW_ONE;
        end
      end else if (start_i) begin
        state_q     <= ST_DEV;
        cnt_q       <= '0;
        sda_oe_o    <= 1'b0;
        wc_seen_q   <= wc_i;
        have_data_q <= 1'b0;
        clr_o       <= 1'b1;
      end else if (stop_i) begin
        sda_oe_o <= 1'b0;
        // one SCL rise after the ACK clock is the 10th slot
        if (state_q == ST_DATA && cnt_q == 4'd1 && have_data_q && !wc_seen_q) begin
          state_q  <= ST_BUSY;
          tw_q     <= TW_W'(TW_EFF);
          commit_o <= 1'b1;
        end else begin
          state_q <= ST_IDLE;
          clr_o   <= 1'b1;
        end
      end else begin
        if ((state_q inside {ST_DEV, ST_ADRH, ST_ADRL}) && wc_i) wc_seen_q <= 1'b1;
        if (scl_rise_i && (state_q inside {ST_DEV, ST_ADRH, ST_ADRL, ST_DATA})) begin
          if (cnt_q < BIT_ACK) sh_q <= {sh_q[6:0], sda_i};
          if (cnt_q < BIT_REL) cnt_q <= cnt_q + 4'd1;
        end
        if (scl_fall_i && (state_q inside {ST_DEV, ST_ADRH, ST_ADRL, ST_DATA})) begin
          if (cnt_q == BIT_ACK) begin
            unique case (state_q)
              ST_DEV: begin
                sda_oe_o <= sel_ok;
                state_q  <= sel_ok ? ST_ADRH : ST_SKIP;
              end
              ST_ADRH: begin
                sda_oe_o  <= 1'b1;
                adr_msb_q <= sh_q;
                state_q   <= ST_ADRL;
              end
              ST_ADRL: begin
                sda_oe_o          <= 1'b1;
                {page_q, off_q}   <= {adr_msb_q, sh_q};
                state_q           <= ST_DATA;
              end
              default: begin
                if (!wc_seen_q) begin
                  sda_oe_o    <= 1'b1;
                  wr_en_o     <= 1'b1;
                  wr_off_o    <= off_q;
                  wr_data_o   <= sh_q;
                  last_q      <= {page_q, off_q};
                  off_q       <= off_q + OFF_ONE;
                  have_data_q <= 1'b1;
                end
              end
            endcase
          end else if (cnt_q == BIT_REL) begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_ee_write.sv
module i2c_ee_write #(
  parameter int MEM_AW    = 8,
  parameter int PAGE_AW   = 6,
  parameter int TW_CYCLES = 300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wc_i,
  input  logic [2:0]        ce_i,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic [15:0]       addr_cnt_o,
  input  logic [MEM_AW-1:0] mem_raddr_i,
  output logic [7:0]        mem_rdata_o
);
  logic scl_rise, scl_fall, start, stop;
  logic wr_en, clr, commit;
  logic [PAGE_AW-1:0]        wr_off;
  logic [7:0]                wr_data;
  logic [MEM_AW-PAGE_AW-1:0] page;

  i2c_ee_bus_mon u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_ee_ctrl #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .TW_CYCLES(TW_CYCLES)) u_ctrl (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop),
    .sda_i, .wc_i, .ce_i,
    .sda_oe_o, .busy_o, .addr_cnt_o,
    .wr_en_o(wr_en), .wr_off_o(wr_off), .wr_data_o(wr_data),
    .clr_o(clr), .commit_o(commit), .page_o(page)
  );

  i2c_ee_page_store #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_store (
    .clk_i, .rst_ni,
    .clr_i(clr), .wr_en_i(wr_en), .wr_off_i(wr_off), .wr_data_i(wr_data),
    .commit_i(commit), .page_i(page),
    .raddr_i(mem_raddr_i), .rdata_o(mem_rdata_o)
  );
endmodule

// File: rtl/i2c_ee_write_chk.sv
module i2c_ee_write_chk #(
  parameter int MEM_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_i,
  input logic              sda_oe_o,
  input logic              busy_o,
  input logic [15:0]       addr_cnt_o,
  input logic [MEM_AW-1:0] mem_raddr_i,
  input logic [7:0]        mem_rdata_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r8_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$stable(sda_oe_o)) |-> !$past(scl_i));

  a_r6_deaf_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);

  a_r5_cycle_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(busy_o)) |-> ($past(scl_i) && $past(sda_i)));

  a_r7_cnt_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$stable(addr_cnt_o)) |-> $fell(busy_o));

  a_r9_array_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !busy_o && !$past(busy_o) && $stable(mem_raddr_i)) |-> $stable(mem_rdata_o));
endmodule

bind i2c_ee_write i2c_ee_write_chk #(.MEM_AW(MEM_AW)) u_chk (.*);

// File: tb/i2c_ee_write_test.sv
module i2c_ee_write_test;
  localparam int MEM_AW = 8;
  localparam int PAGE_AW = 6;
  localparam int TW = 300;
  localparam int Q = 2;
  localparam logic [2:0] CE = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, CE, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wc = 1'b0;
  logic [MEM_AW-1:0] raddr = '0;
  logic sda_oe, busy, sda_line;
  logic [15:0] acnt;
  logic [7:0] rdata;

  assign sda_line = m_sda & ~sda_oe;
  always #4 clk = ~clk;

  i2c_ee_write #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .TW_CYCLES(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line), .wc_i(wc),
    .ce_i(CE), .sda_oe_o(sda_oe), .busy_o(busy), .addr_cnt_o(acnt),
    .mem_raddr_i(raddr), .mem_rdata_o(rdata)
  );

  int checks = 0, failures = 0, oe_bad = 0;
  logic [7:0]  exp_mem [256];
  logic [15:0] exp_cnt;
  logic [15:0] cur_a;
  bit          cur_blk;
  int          cur_n;
  logic [15:0] pa [128];
  logic [7:0]  pd [128];
  bit          ack, eb;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); m_sda = 1'b0; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; hq(); m_scl = 1'b1; hq(); m_sda = 1'b1; hq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int k);
    for (int i = 7; i > 7 - k; i--) begin
      m_sda = b[i]; hq(); m_scl = 1'b1; hq();
      if (sda_oe) oe_bad++;
      hq(); m_scl = 1'b0; hq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit a);
    send_bits(b, 8);
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq();
    a = !sda_line;
    hq(); m_scl = 1'b0; hq();
  endtask

  // wcmode: 0 none, 1 high across START, 2 high during low address byte, 3 high in data phase
  task automatic txn_begin(input logic [15:0] a, input int wcmode);
    bit k;
    cur_a = a; cur_blk = (wcmode == 1 || wcmode == 2); cur_n = 0;
    wc = (wcmode == 1);
    i2c_start();
    wc = 1'b0;
    send_byte(SEL_W, k);  check(k, "R1 select ack", k, 1);
    send_byte(a[15:8], k); check(k, "R2 addr hi ack", k, 1);
    wc = (wcmode == 2);
    send_byte(a[7:0], k);  check(k, "R2 addr lo ack", k, 1);
    wc = (wcmode == 3);
  endtask

  task automatic txn_byte(input logic [7:0] d);
    bit k;
    logic [PAGE_AW-1:0] o;
    send_byte(d, k);
    if (cur_blk) check(!k, "R4 data nack", k, 0);
    else         check(k, "R3 data ack", k, 1);
    o = cur_a[PAGE_AW-1:0] + PAGE_AW'(cur_n);
    if (cur_n < 128) begin
      pa[cur_n] = {cur_a[15:PAGE_AW], o};
      pd[cur_n] = d;
      cur_n++;
    end
  endtask

  task automatic txn_stop(output bit exp_busy);
    i2c_stop();
    wc = 1'b0;
    exp_busy = !cur_blk && cur_n > 0;
    if (exp_busy) begin
      for (int i = 0; i < cur_n; i++) exp_mem[pa[i][7:0]] = pd[i];
      exp_cnt = pa[cur_n-1] + 16'd1;
    end
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0;
    int first = 0;
    logic [7:0] fa = '0, fe = '0;
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      raddr = i[7:0];
      #1;
      if (rdata !== exp_mem[i]) begin
        if (bad == 0) begin first = i; fa = rdata; fe = exp_mem[i]; end
        bad++;
      end
    end
    check(bad == 0, req, {8'(first), 8'(bad), fa}, {8'(first), 8'd0, fe});
  endtask

  task automatic finish_txn(input bit exp_busy, input string req);
    repeat (4) @(negedge clk);
    check(busy == exp_busy, "R6 busy after STOP", busy, exp_busy);
    repeat (TW + 10) @(negedge clk);
    check(!busy, "R6 busy ends", busy, 0);
    check(acnt == exp_cnt, "R7 address counter", acnt, exp_cnt);
    mem_cmp(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R6 act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0427));
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    exp_cnt = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!sda_oe, "R8 reset oe", sda_oe, 0);
    check(!busy, "R6 reset busy", busy, 0);
    check(acnt == 16'h0, "R7 reset counter", acnt, 0);
    mem_cmp("R9 reset array");

    // R1: wrong device type, then following bytes ignored
    i2c_start();
    send_byte(8'hB0, ack); check(!ack, "R1 type mismatch", ack, 0);
    send_byte(8'h00, ack); check(!ack, "R1 idle until START", ack, 0);
    send_byte(8'h12, ack); check(!ack, "R1 idle until START", ack, 0);
    i2c_stop();
    finish_txn(1'b0, "R1 array untouched");

    // R1: chip-enable mismatch
    i2c_start();
    send_byte({4'b1010, 3'b100, 1'b0}, ack); check(!ack, "R1 ce mismatch", ack, 0);
    i2c_stop();
    // R1: read bit set
    i2c_start();
    send_byte({4'b1010, CE, 1'b1}, ack); check(!ack, "R1 read select", ack, 0);
    i2c_stop();
    check(!busy, "R1 no cycle", busy, 0);

    // R2: byte write, upper address bits alias
    txn_begin(16'h1234, 0); txn_byte(8'h5C); txn_stop(eb);
    finish_txn(eb, "R2 byte write");

    // R6: deaf during write cycle
    txn_begin(16'h0010, 0); txn_byte(8'hA1); txn_byte(8'hA2); txn_stop(eb);
    repeat (2) @(negedge clk);
    i2c_start();
    send_byte(SEL_W, ack); check(!ack, "R6 select ignored while busy", ack, 0);
    check(busy, "R6 still busy", busy, 1);
    i2c_stop();
    finish_txn(eb, "R9 page write after busy probe");

    // R4: protection window
    txn_begin(16'h0040, 1); txn_byte(8'h31); txn_byte(8'h32); txn_stop(eb);
    finish_txn(eb, "R4 wc at START");
    txn_begin(16'h0044, 2); txn_byte(8'h41); txn_stop(eb);
    finish_txn(eb, "R4 wc at low address byte");
    txn_begin(16'h0048, 3); txn_byte(8'h51); txn_byte(8'h52); txn_stop(eb);
    finish_txn(eb, "R4 wc in data phase ignored");

    // R5: STOP in wrong slot
    txn_begin(16'h0020, 0); txn_byte(8'h11);
    send_bits(8'hF0, 3);
    i2c_stop();
    finish_txn(1'b0, "R5 stop mid-byte");
    // R5: STOP with no data byte
    txn_begin(16'h0030, 0); txn_stop(eb);
    finish_txn(eb, "R5 stop without data");
    // R5: repeated START discards buffered bytes
    txn_begin(16'h0050, 0); txn_byte(8'hE1); txn_byte(8'hE2);
    txn_begin(16'h00A0, 0); txn_byte(8'h77); txn_stop(eb);
    finish_txn(eb, "R5 repeated START");

    // R3: page wrap and overwrite
    txn_begin(16'h013E, 0);
    for (int i = 0; i < 4; i++) txn_byte(8'hC0 + 8'(i));
    txn_stop(eb);
    finish_txn(eb, "R3 page wrap");
    check(acnt == 16'h0102, "R7 counter after wrap", acnt, 16'h0102);
    txn_begin(16'h0080, 0);
    for (int i = 0; i < 66; i++) txn_byte(8'(i * 3 + 1));
    txn_stop(eb);
    finish_txn(eb, "R3 overwrite in page");

    // random mix
    for (int t = 0; t < 12; t++) begin
      logic [15:0] ra;
      int rn, rm;
      ra = 16'($urandom);
      rn = 1 + int'($urandom % 70);
      rm = ($urandom % 4 == 0) ? 2 : 0;
      txn_begin(ra, rm);
      for (int i = 0; i < rn; i++) txn_byte(8'($urandom));
      txn_stop(eb);
      finish_txn(eb, "R3 random page write");
    end

    check(oe_bad == 0, "R8 oe outside ACK slot", oe_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule